// File: doc/BRIEF.md
# Master-Clocked Serial Byte Receiver with Optional Second Buffer

This block receives 8-bit frames over a two-wire synchronous link in which it is the clock master. It drives a shift clock toward the sender, samples the incoming data line on each rising edge of that clock, and assembles frames least significant bit first. The clock rate comes from a programmable divider of the system clock, and the clock rests high whenever no bit is in flight.

Finished frames land in a holding register that the host reads through `rd_data`, acknowledging with a one-cycle read strobe. With the second buffer disabled, the block receives one frame, then keeps the clock parked until the host reads. With it enabled, the shift stage keeps receiving while the holding register waits. If a further frame completes before the host has read, that frame stays in the shift stage and the clock freezes. The host read then releases it. Every transfer into the holding register raises a buffer-full flag and a one-cycle interrupt pulse.

Top module: `ser_rx_master`

## Requirements
- R1: While reset is held and just after it is released, `sclk_out` is 1, `buf_full` is 0, `rx_irq` is 0 and `rd_data` is 0.
- R2: A frame is 8 bits sampled on successive rising edges of `sclk_out`. The first sampled bit becomes `rd_data[0]` and the eighth becomes `rd_data[7]`.
- R3: While `rx_en` is 0, `sclk_out` never falls. Raising `rx_en` starts clock pulses. Lowering it lets the bit already in flight finish and then holds the clock high.
- R4: Each low phase of `sclk_out`, and each high phase between bits, lasts `half_div`+1 system clock cycles.
- R5: With `dbl_buf_en`=0, the block receives exactly one frame and then keeps `sclk_out` high while `buf_full` is 1. A host read clears `buf_full` and lets the next frame start.
- R6: `rx_irq` is high for exactly one cycle. It rises one cycle after each transfer of a frame into the holding register, and at no other time.
- R7: With `dbl_buf_en`=1 and the holding register empty, a completed frame transfers at once, sets `buf_full`, raises `rx_irq`, and reception of the next frame continues without pause.
- R8: With `dbl_buf_en`=1, a frame that completes while `buf_full` is 1 and no read occurs in that cycle raises no `rx_irq`. That frame stays in the shift stage and `sclk_out` stops high.
- R9: A read while a frame is held back transfers that frame to `rd_data`, raises `rx_irq`, keeps `buf_full` at 1 and restarts the clock.
- R10: A read with no frame held back and no frame completing clears `buf_full` one cycle later. `rd_data` keeps its value.
- R11: Lowering `rx_en` in the middle of a frame discards the bits gathered so far. After re-enabling, the next frame is assembled from fresh bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| dbl_buf_en | input | 1 | Enables the second (holding-while-shifting) buffer mode |
| half_div | input | DIV_W | Each clock phase lasts half_div+1 system cycles |
| sdi | input | 1 | Serial data from the sender |
| rd_stb | input | 1 | One-cycle host read strobe |
| sclk_out | output | 1 | Shift clock driven to the sender, idles high |
| rd_data | output | FRAME_W | Holding register contents |
| buf_full | output | 1 | Holding register contains an unread frame |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench acts as the sender. It changes the data line on every falling edge of the shift clock and sweeps all 256 byte values in single-buffer mode. That exposes bit-order reversal and off-by-one bit counts, which would show up as wrong bytes or nine-edge frames. In double-buffer mode the host deliberately stops reading. A design that ignored the full holding register would keep clocking, overwrite unread data or fire a second interrupt. A design that mishandled the stalled read would lose the held-back frame or drop the full flag. The bench also measures phase lengths for several divider settings and drops the enable mid-frame. A design that kept the partial bits would deliver a byte shifted by the stale bit count.

// File: rtl/ser_rx_pkg.sv
`timescale 1ns/1ps
package ser_rx_pkg;
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } sclk_phase_e;

  typedef enum logic [1:0] {
    MV_NONE    = 2'd0,
    MV_FRESH   = 2'd1,
    MV_PENDING = 2'd2
  } move_kind_e;
endpackage

// File: rtl/ser_rx_sclk_gen.sv
`timescale 1ns/1ps
module ser_rx_sclk_gen
  import ser_rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise
);
  sclk_phase_e      phase;
  logic [DIV_W-1:0] pc;
  logic             at_end;

  function automatic logic phase_over(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] lim);
    return cnt >= lim;
  endfunction

  assign at_end = phase_over(pc, half_div);
  assign rise   = (phase == PH_LOW) && at_end;
  assign sclk   = (phase == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HIGH;
      pc    <= '0;
    end else if (phase == PH_LOW) begin
      if (at_end) begin
        phase <= PH_HIGH;
        pc    <= '0;
      end else begin
        pc <= pc + 1'b1;
      end
    end else begin
      if (at_end) begin
        if (run) begin
          phase <= PH_LOW;
          pc    <= '0;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  a_r4_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW && !at_end) |=> (phase == PH_LOW));
  a_r4_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !at_end) |=> (phase == PH_HIGH));
endmodule

// File: rtl/ser_rx_shifter.sv
`timescale 1ns/1ps
module ser_rx_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               rise,
  input  logic               sdi,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word,
  output logic [FRAME_W-1:0] held_word
);
  localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  function automatic logic [FRAME_W-1:0] push_lsb_first(
    input logic [FRAME_W-1:0] cur, input logic b);
    return {b, cur[FRAME_W-1:1]};
  endfunction

  assign frame_word = push_lsb_first(sh, sdi);
  assign frame_done = rise && (cnt == LAST_BIT);
  assign held_word  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (rise) begin
      sh  <= frame_word;
      cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
    end else if (!rx_en) begin
      cnt <= '0;
    end
  end

  a_r11_idle_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rise) |=> (cnt == '0));
  a_r2_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt != LAST_BIT) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ser_rx_hold_ctrl.sv
`timescale 1ns/1ps
module ser_rx_hold_ctrl
  import ser_rx_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbl_en,
  input  logic               rd_stb,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [FRAME_W-1:0] held_word,
  output logic [FRAME_W-1:0] hold_word,
  output logic               buf_full,
  output logic               pend,
  output logic               irq,
  output logic               run_ok,
  output move_kind_e         move
);
  always_comb begin
    move = MV_NONE;
    if (frame_done && (!buf_full || rd_stb)) move = MV_FRESH;
    else if (rd_stb && pend)                 move = MV_PENDING;
  end

  assign run_ok = !pend && (dbl_en || !buf_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      buf_full  <= 1'b0;
      pend      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= (move != MV_NONE);
      unique case (move)
        MV_FRESH:   hold_word <= frame_word;
        MV_PENDING: hold_word <= held_word;
        default:    hold_word <= hold_word;
      endcase
      if (move != MV_NONE) buf_full <= 1'b1;
      else if (rd_stb)     buf_full <= 1'b0;
      if (frame_done && buf_full && !rd_stb) pend <= 1'b1;
      else if (rd_stb)                       pend <= 1'b0;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r7_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_full);
  a_r8_no_frame_while_pend: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !frame_done);
  a_r8_stall_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && buf_full && !rd_stb) |=> (!irq && pend));
  a_r9_pend_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && rd_stb) |=> (irq && buf_full && !pend));
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pend && !frame_done) |=> (!buf_full && $stable(hold_word)));
endmodule

// File: rtl/ser_rx_master.sv
`timescale 1ns/1ps
module ser_rx_master
  import ser_rx_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               dbl_buf_en,
  input  logic [DIV_W-1:0]   half_div,
  input  logic               sdi,
  input  logic               rd_stb,
  output logic               sclk_out,
  output logic [FRAME_W-1:0] rd_data,
  output logic               buf_full,
  output logic               rx_irq
);
  logic               run;
  logic               run_ok;
  logic               rise;
  logic               frame_done;
  logic               pend;
  logic [FRAME_W-1:0] frame_word;
  logic [FRAME_W-1:0] held_word;
  move_kind_e         move;

  assign run = rx_en && run_ok;

  ser_rx_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (half_div),
    .sclk     (sclk_out),
    .rise     (rise)
  );

  ser_rx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rise       (rise),
    .sdi        (sdi),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .held_word  (held_word)
  );

  ser_rx_hold_ctrl #(.FRAME_W(FRAME_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl_en     (dbl_buf_en),
    .rd_stb     (rd_stb),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .held_word  (held_word),
    .hold_word  (rd_data),
    .buf_full   (buf_full),
    .pend       (pend),
    .irq        (rx_irq),
    .run_ok     (run_ok),
    .move       (move)
  );

  a_r3_no_fall_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_out) |-> $past(rx_en));
  a_r5_single_parks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_out) |-> ($past(dbl_buf_en) || !$past(buf_full)));
  a_r8_stall_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_out) |-> !$past(pend));
  a_r6_irq_after_move: assert property (@(posedge clk) disable iff (!rst_n)
    (move != MV_NONE) |=> rx_irq);
endmodule

// File: tb/ser_rx_master_bench.sv
`timescale 1ns/1ps
module ser_rx_master_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic       dbl_buf_en;
  logic [7:0] half_div;
  logic       sdi;
  logic       rd_stb;
  logic       sclk_out;
  logic [7:0] rd_data;
  logic       buf_full;
  logic       rx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int rises    = 0;
  int fidx     = 0;
  int bpos     = 0;
  int irqs     = 0;
  int irq_wide = 0;
  logic irq_prev = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  ser_rx_master u_ser_rx_master (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_buf_en(dbl_buf_en),
    .half_div(half_div), .sdi(sdi), .rd_stb(rd_stb), .sclk_out(sclk_out),
    .rd_data(rd_data), .buf_full(buf_full), .rx_irq(rx_irq)
  );

  function automatic logic [7:0] val_of(input int f);
    return 8'((f * 73 + 19) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sender: next bit on each falling edge of the shift clock
  initial forever begin
    logic [7:0] v;
    @(negedge sclk_out);
    v = val_of(fidx);
    sdi = v[bpos];
  end

  initial forever begin
    @(posedge sclk_out);
    rises++;
    if (bpos == 7) begin bpos = 0; fidx++; end
    else bpos++;
  end

  initial forever begin
    @(negedge clk);
    if (rx_irq) irqs++;
    if (rx_irq && irq_prev) irq_wide++;
    irq_prev = rx_irq;
  end

  task automatic host_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic wait_quiet();
    int r;
    do begin
      r = rises;
      repeat (40) @(negedge clk);
    end while (r != rises);
  endtask

  task automatic wait_irq(input int target, input string req);
    int t = 0;
    while (irqs < target && t < 4000) begin @(negedge clk); t++; end
    chk(irqs >= target, req, irqs, target);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, i0, f0, lo, hi;
    rst_n = 1'b0; rx_en = 1'b0; dbl_buf_en = 1'b0; half_div = 8'd0;
    sdi = 1'b0; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk_out == 1'b1, "R1 sclk in reset", sclk_out, 1);
    rst_n = 1'b1;
    rises = 0; fidx = 0; bpos = 0; irqs = 0;
    @(negedge clk);
    chk(sclk_out == 1'b1 && buf_full == 1'b0 && rx_irq == 1'b0, "R1 flags",
        {sclk_out, buf_full, rx_irq}, 4);
    chk(rd_data == 8'd0, "R1 data", rd_data, 0);

    repeat (40) @(negedge clk);
    chk(rises == 0, "R3 no clock while disabled", rises, 0);

    // R2 / R5: every byte value in single-buffer mode
    rx_en = 1'b1;
    for (int f = 0; f < 256; f++) begin
      wait_irq(f + 1, "R6 irq per frame");
      wait_quiet();
      chk(rd_data == val_of(f), "R2 byte value", rd_data, val_of(f));
      chk(rises == 8 * (f + 1) && buf_full, "R5 parked after one frame", rises, 8 * (f + 1));
      if (f == 255) rx_en = 1'b0;
      host_read();
    end
    chk(buf_full == 1'b0, "R10 read clears full", buf_full, 0);
    wait_quiet();
    chk(rises == 2048, "R3 stays stopped after disable", rises, 2048);

    // R4 divider and R11 discard
    for (int k = 0; k < 3; k++) begin
      int hd;
      hd = (k == 0) ? 1 : (k == 1) ? 2 : 5;
      half_div = 8'(hd);
      f0 = fidx;
      rx_en = 1'b1;
      @(negedge sclk_out);
      lo = 0; hi = 0;
      @(negedge clk);
      while (sclk_out == 1'b0) begin lo++; @(negedge clk); end
      while (sclk_out == 1'b1) begin hi++; @(negedge clk); end
      chk(lo == hd + 1, "R4 low phase", lo, hd + 1);
      chk(hi == hd + 1, "R4 high phase", hi, hd + 1);
      rx_en = 1'b0;
      wait_quiet();
      bpos = 0;
      i0 = irqs;
      rx_en = 1'b1;
      wait_irq(i0 + 1, "R11 frame after re-enable");
      chk(rd_data == val_of(f0), "R11 partial discarded", rd_data, val_of(f0));
      rx_en = 1'b0;
      wait_quiet();
      host_read();
    end

    // R7 / R8 / R9 double buffering with a slow host
    half_div = 8'd1; dbl_buf_en = 1'b1;
    f0 = fidx; r0 = rises; i0 = irqs;
    rx_en = 1'b1;
    wait_quiet();
    chk(rises - r0 == 16, "R8 stall after second frame", rises - r0, 16);
    chk(irqs - i0 == 1, "R8 no irq on stalled frame", irqs - i0, 1);
    chk(rd_data == val_of(f0) && buf_full, "R7 first frame held", rd_data, val_of(f0));
    host_read();
    chk(rd_data == val_of(f0 + 1), "R9 pending frame moved", rd_data, val_of(f0 + 1));
    chk(buf_full && rx_irq, "R9 full kept and irq", {buf_full, rx_irq}, 3);
    wait_quiet();
    chk(rises - r0 == 24, "R8 stall again", rises - r0, 24);
    chk(irqs - i0 == 2, "R6 irq count", irqs - i0, 2);
    rx_en = 1'b0;
    host_read();
    chk(rd_data == val_of(f0 + 2) && buf_full, "R9 stalled read while disabled", rd_data, val_of(f0 + 2));
    host_read();
    chk(!buf_full, "R10 full clears", buf_full, 0);
    chk(rd_data == val_of(f0 + 2), "R10 data kept", rd_data, val_of(f0 + 2));

    // R7 fast host: no stall
    f0 = fidx; i0 = irqs;
    rx_en = 1'b1;
    for (int j = 0; j < 6; j++) begin
      wait_irq(i0 + j + 1, "R7 irq per frame");
      chk(rd_data == val_of(f0 + j), "R7 streamed byte", rd_data, val_of(f0 + j));
      host_read();
    end
    rx_en = 1'b0;
    wait_quiet();
    chk(irq_wide == 0, "R6 pulse width", irq_wide, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule